// File: doc/BRIEF.md
# Display Transmitter I2C Register Front End with DDC Handshake

This block is the byte-level register side of a display transmitter that answers on an I2C bus. A separate bit-level engine decodes SCL/SDA, matches the device address and hands this block one-cycle strobes. There are four of them: a start of a write transfer, a start of a read transfer, a received byte with its data, and a request for a byte to send. The block keeps an 8-bit register pointer. It answers reads for the identification and interrupt status registers, and it ignores writes to registers it does not model.

The system control register carries a request/grant handshake. A host that sets the request and grant bits together moves the device into DDC pass-through mode. A registered output reports that mode to an external bus multiplexer, which then routes the host to the EDID memory. Clearing the request bit returns the device to normal mode.

Top module: `disp_i2c_regfront`

## Requirements
- R1: After reset the pointer is 0x00, `ddc_mode` is 0, `rd_byte` is 0x00 and no DDC request is pending.
- R2: The first byte received after a write-start strobe loads the pointer and is not written to any register. Every later byte in that transfer is data.
- R3: The pointer advances by one after each data byte written and after each byte read, and wraps from 0xFF to 0x00.
- R4: A read-start strobe leaves the pointer unchanged, so a pointer write followed by a read-start reads from that address. A read-start also cancels a pending pointer byte.
- R5: A read at address 0x1B returns 0xB0.
- R6: A read at address 0x3D returns 0x04 (sink attached, no hot-plug event). Writes to 0x3C, the interrupt enable register, are ignored, and 0x3C reads 0x00.
- R7: A data write to 0x1A with bit 2 (request) and bit 1 (grant) both set makes `ddc_mode` 1 from the clock edge that takes the byte.
- R8: A data write to 0x1A with bit 2 set and bit 1 clear records a pending request and leaves `ddc_mode` unchanged.
- R9: A data write to 0x1A with bit 2 clear clears both the pending request and `ddc_mode`.
- R10: A read of 0x1A returns 0x06 while a request is pending and 0x00 otherwise. Every address other than 0x1A, 0x1B and 0x3D reads 0x00, and writes to those addresses change nothing but the pointer.
- R11: `rd_byte` is registered. It takes its new value on the edge that accepts `ev_rd_req` and holds it until the next read request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ev_wr_start | input | 1 | Strobe: write transfer started |
| ev_rd_start | input | 1 | Strobe: read transfer started |
| ev_wr_byte | input | 1 | Strobe: byte received |
| wr_byte | input | 8 | Received byte, valid with `ev_wr_byte` |
| ev_rd_req | input | 1 | Strobe: engine needs the next byte to send |
| rd_byte | output | 8 | Byte to send, registered |
| ddc_mode | output | 1 | DDC pass-through mode, to the bus multiplexer |

## Verification
The bench builds the block with its default parameters: control at 0x1A, identification at 0x1B, interrupt enable at 0x3C, status at 0x3D, and identification value 0xB0. With an 8-bit pointer these settings let the bench set the pointer to 0xFF and then read 28 bytes past the wrap until it sees the identification value. That read shows the wrap happened, instead of a saturating pointer. Random traffic biased toward the four modelled addresses covers every ordering of the request and grant bits across transfers.

// File: rtl/disp_regfront_pkg.sv
package disp_regfront_pkg;

  typedef logic [7:0] byte_t;

  // pointer step, wrapping at the byte boundary
  function automatic byte_t ptr_step(input byte_t p);
    return p + 8'd1;
  endfunction

  // value the control register returns for a given request state
  function automatic byte_t ctl_readback(input logic req, input int unsigned req_bit,
                                         input int unsigned gnt_bit);
    byte_t v;
    v = '0;
    if (req) begin
      v[req_bit] = 1'b1;
      v[gnt_bit] = 1'b1;
    end
    return v;
  endfunction

endpackage

// File: rtl/disp_ptr_unit.sv
module disp_ptr_unit
  import disp_regfront_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  ev_wr_start,
  input  logic  ev_rd_start,
  input  logic  ev_wr_byte,
  input  logic  ev_rd_req,
  input  byte_t wr_byte,
  output byte_t ptr,
  output logic  data_wr
);

  logic  expect_ptr;
  logic  ptr_load;

  assign ptr_load = ev_wr_byte && expect_ptr && !ev_wr_start && !ev_rd_start;
  assign data_wr  = ev_wr_byte && !expect_ptr && !ev_wr_start && !ev_rd_start;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ptr        <= '0;
      expect_ptr <= 1'b0;
    end else if (ev_wr_start) begin
      expect_ptr <= 1'b1;
    end else if (ev_rd_start) begin
      expect_ptr <= 1'b0;
    end else if (ptr_load) begin
      ptr        <= wr_byte;
      expect_ptr <= 1'b0;
    end else if (data_wr || ev_rd_req) begin
      ptr        <= ptr_step(ptr);
    end
  end

endmodule

// File: rtl/disp_ddc_ctl.sv
module disp_ddc_ctl
  import disp_regfront_pkg::*;
#(
  parameter int unsigned REQ_BIT = 2,
  parameter int unsigned GNT_BIT = 1
) (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  ctl_wr,
  input  byte_t wr_byte,
  output logic  ddc_req,
  output logic  ddc_mode
);

  logic want_req;
  logic want_gnt;

  assign want_req = wr_byte[REQ_BIT];
  assign want_gnt = wr_byte[GNT_BIT];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ddc_req  <= 1'b0;
      ddc_mode <= 1'b0;
    end else if (ctl_wr) begin
      if (want_req) begin
        ddc_req <= 1'b1;
        if (want_gnt) ddc_mode <= 1'b1;
      end else begin
        ddc_req  <= 1'b0;
        ddc_mode <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/disp_rd_mux.sv
module disp_rd_mux
  import disp_regfront_pkg::*;
#(
  parameter byte_t       CTL_ADDR  = 8'h1A,
  parameter byte_t       ID_ADDR   = 8'h1B,
  parameter byte_t       STAT_ADDR = 8'h3D,
  parameter byte_t       ID_VALUE  = 8'hB0,
  parameter byte_t       STAT_VAL  = 8'h04,
  parameter int unsigned REQ_BIT   = 2,
  parameter int unsigned GNT_BIT   = 1
) (
  input  byte_t ptr,
  input  logic  ddc_req,
  output byte_t rd_next
);

  always_comb begin
    rd_next = '0;
    if (ptr == CTL_ADDR)       rd_next = ctl_readback(ddc_req, REQ_BIT, GNT_BIT);
    else if (ptr == ID_ADDR)   rd_next = ID_VALUE;
    else if (ptr == STAT_ADDR) rd_next = STAT_VAL;
  end

endmodule

// File: rtl/disp_i2c_regfront.sv
module disp_i2c_regfront
  import disp_regfront_pkg::*;
#(
  parameter byte_t       CTL_ADDR  = 8'h1A,
  parameter byte_t       ID_ADDR   = 8'h1B,
  parameter byte_t       IEN_ADDR  = 8'h3C,
  parameter byte_t       STAT_ADDR = 8'h3D,
  parameter byte_t       ID_VALUE  = 8'hB0,
  parameter int unsigned PLUG_BIT  = 2,
  parameter int unsigned REQ_BIT   = 2,
  parameter int unsigned GNT_BIT   = 1
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ev_wr_start,
  input  logic       ev_rd_start,
  input  logic       ev_wr_byte,
  input  logic [7:0] wr_byte,
  input  logic       ev_rd_req,
  output logic [7:0] rd_byte,
  output logic       ddc_mode
);

  localparam byte_t STAT_VAL = byte_t'(1) << PLUG_BIT;

  byte_t ptr;
  byte_t rd_next;
  logic  data_wr;
  logic  ctl_wr;
  logic  ien_wr;
  logic  ddc_req;

  disp_ptr_unit u_ptr (
    .clk        (clk),
    .rst_n      (rst_n),
    .ev_wr_start(ev_wr_start),
    .ev_rd_start(ev_rd_start),
    .ev_wr_byte (ev_wr_byte),
    .ev_rd_req  (ev_rd_req),
    .wr_byte    (wr_byte),
    .ptr        (ptr),
    .data_wr    (data_wr)
  );

  // named events for the checker
  assign ctl_wr = data_wr && (ptr == CTL_ADDR);
  assign ien_wr = data_wr && (ptr == IEN_ADDR);

  disp_ddc_ctl #(.REQ_BIT(REQ_BIT), .GNT_BIT(GNT_BIT)) u_ctl (
    .clk     (clk),
    .rst_n   (rst_n),
    .ctl_wr  (ctl_wr),
    .wr_byte (wr_byte),
    .ddc_req (ddc_req),
    .ddc_mode(ddc_mode)
  );

  disp_rd_mux #(
    .CTL_ADDR (CTL_ADDR),
    .ID_ADDR  (ID_ADDR),
    .STAT_ADDR(STAT_ADDR),
    .ID_VALUE (ID_VALUE),
    .STAT_VAL (STAT_VAL),
    .REQ_BIT  (REQ_BIT),
    .GNT_BIT  (GNT_BIT)
  ) u_mux (
    .ptr    (ptr),
    .ddc_req(ddc_req),
    .rd_next(rd_next)
  );

  always_ff @(posedge clk) begin
    if (!rst_n)         rd_byte <= '0;
    else if (ev_rd_req) rd_byte <= rd_next;
  end

endmodule

// File: rtl/disp_regfront_chk.sv
module disp_regfront_chk #(
  parameter logic [7:0] ID_ADDR  = 8'h1B,
  parameter logic [7:0] ID_VALUE = 8'hB0
) (
  input logic       clk,
  input logic       rst_n,
  input logic       ev_rd_start,
  input logic       ev_rd_req,
  input logic       data_wr,
  input logic       ctl_wr,
  input logic       ien_wr,
  input logic [7:0] wr_byte,
  input logic [7:0] ptr,
  input logic       ddc_req,
  input logic       ddc_mode,
  input logic [7:0] rd_byte
);

  a_r7_grant_enters_ddc: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_wr && wr_byte[2] && wr_byte[1]) |=> ddc_mode);

  a_r8_request_keeps_mode: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_wr && wr_byte[2] && !wr_byte[1]) |=> (ddc_req && ddc_mode == $past(ddc_mode)));

  a_r9_drop_clears_both: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_wr && !wr_byte[2]) |=> (!ddc_mode && !ddc_req));

  a_r10_mode_needs_req: assert property (@(posedge clk) disable iff (!rst_n)
    ddc_mode |-> ddc_req);

  a_r3_ptr_steps_on_write: assert property (@(posedge clk) disable iff (!rst_n)
    data_wr |=> (ptr == $past(ptr) + 8'd1));

  a_r4_rd_start_holds_ptr: assert property (@(posedge clk) disable iff (!rst_n)
    ev_rd_start |=> $stable(ptr));

  a_r5_id_read: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_rd_req && ptr == ID_ADDR) |=> (rd_byte == ID_VALUE));

  a_r6_ien_write_no_effect: assert property (@(posedge clk) disable iff (!rst_n)
    ien_wr |=> ($stable(ddc_mode) && $stable(ddc_req)));

  a_r11_rd_byte_holds: assert property (@(posedge clk) disable iff (!rst_n)
    !ev_rd_req |=> $stable(rd_byte));

endmodule

bind disp_i2c_regfront disp_regfront_chk #(.ID_ADDR(ID_ADDR), .ID_VALUE(ID_VALUE)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .ev_rd_start(ev_rd_start),
  .ev_rd_req  (ev_rd_req),
  .data_wr    (data_wr),
  .ctl_wr     (ctl_wr),
  .ien_wr     (ien_wr),
  .wr_byte    (wr_byte),
  .ptr        (ptr),
  .ddc_req    (ddc_req),
  .ddc_mode   (ddc_mode),
  .rd_byte    (rd_byte)
);

// File: tb/tb_disp_i2c_regfront.sv
module tb_disp_i2c_regfront;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ev_wr_start = 1'b0;
  logic       ev_rd_start = 1'b0;
  logic       ev_wr_byte = 1'b0;
  logic [7:0] wr_byte = 8'h00;
  logic       ev_rd_req = 1'b0;
  logic [7:0] rd_byte;
  logic       ddc_mode;

  int total = 0;
  int bad = 0;

  // bench model of the register front end
  logic [7:0] m_ptr = 8'h00;
  logic       m_expect = 1'b0;
  logic       m_req = 1'b0;
  logic       m_ddc = 1'b0;

  always #5 clk = ~clk;

  disp_i2c_regfront dut (
    .clk        (clk),
    .rst_n      (rst_n),
    .ev_wr_start(ev_wr_start),
    .ev_rd_start(ev_rd_start),
    .ev_wr_byte (ev_wr_byte),
    .wr_byte    (wr_byte),
    .ev_rd_req  (ev_rd_req),
    .rd_byte    (rd_byte),
    .ddc_mode   (ddc_mode)
  );

  function automatic logic [7:0] want_read(input logic [7:0] a, input logic req);
    case (a)
      8'h1A:   return req ? 8'h06 : 8'h00;
      8'h1B:   return 8'hB0;
      8'h3D:   return 8'h04;
      default: return 8'h00;
    endcase
  endfunction

  function automatic string tag_for(input logic [7:0] a);
    case (a)
      8'h1A:   return "R10";
      8'h1B:   return "R5";
      8'h3C:   return "R6";
      8'h3D:   return "R6";
      default: return "R10";
    endcase
  endfunction

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic do_wr_start();
    @(negedge clk) ev_wr_start = 1'b1;
    @(negedge clk) ev_wr_start = 1'b0;
    m_expect = 1'b1;
  endtask

  task automatic do_rd_start();
    @(negedge clk) ev_rd_start = 1'b1;
    @(negedge clk) ev_rd_start = 1'b0;
    m_expect = 1'b0;
  endtask

  task automatic do_write(input logic [7:0] d);
    @(negedge clk) begin ev_wr_byte = 1'b1; wr_byte = d; end
    @(negedge clk) ev_wr_byte = 1'b0;
    if (m_expect) begin
      m_ptr = d;
      m_expect = 1'b0;
    end else begin
      if (m_ptr == 8'h1A) begin
        if (d[2]) begin
          m_req = 1'b1;
          if (d[1]) m_ddc = 1'b1;
        end else begin
          m_req = 1'b0;
          m_ddc = 1'b0;
        end
      end
      m_ptr = m_ptr + 8'd1;
    end
  endtask

  task automatic do_read(output logic [7:0] exp);
    exp = want_read(m_ptr, m_req);
    @(negedge clk) ev_rd_req = 1'b1;
    @(negedge clk) ev_rd_req = 1'b0;
    m_ptr = m_ptr + 8'd1;
  endtask

  task automatic set_ptr(input logic [7:0] a);
    do_wr_start();
    do_write(a);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [7:0] e;
    logic [7:0] held;
    logic [7:0] a;
    logic [7:0] d;
    int unsigned pick;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    check("R1 rd_byte", rd_byte, 8'h00);
    check("R1 ddc_mode", {7'd0, ddc_mode}, 8'h00);
    do_read(e);
    check("R1 ptr zero", rd_byte, e);

    // R2/R5: pointer load then identification read
    set_ptr(8'h1B);
    do_rd_start();
    do_read(e);
    check("R5 id", rd_byte, 8'hB0);
    check("R2 ptr loaded", rd_byte, e);

    // R3: auto-increment after a read
    set_ptr(8'h1A);
    do_rd_start();
    do_read(e);
    do_read(e);
    check("R3 step after read", rd_byte, 8'hB0);

    // R11: rd_byte holds without a request
    held = rd_byte;
    repeat (4) @(negedge clk);
    check("R11 hold", rd_byte, held);

    // R6: status and interrupt enable
    set_ptr(8'h3C);
    do_write(8'hFF);
    set_ptr(8'h3C);
    do_rd_start();
    do_read(e);
    check("R6 ien ignored", rd_byte, 8'h00);
    do_read(e);
    check("R6 status", rd_byte, 8'h04);

    // R8: request without grant
    set_ptr(8'h1A);
    do_write(8'h04);
    check("R8 mode unchanged", {7'd0, ddc_mode}, 8'h00);
    set_ptr(8'h1A);
    do_rd_start();
    do_read(e);
    check("R10 ctl pending", rd_byte, 8'h06);

    // R7: request and grant together
    set_ptr(8'h1A);
    do_write(8'h06);
    check("R7 ddc on", {7'd0, ddc_mode}, 8'h01);

    // R2: pointer byte is not data (0x1A as address must not clear ddc)
    set_ptr(8'h1A);
    check("R2 addr byte not data", {7'd0, ddc_mode}, 8'h01);

    // R4: rd_start keeps pointer
    do_rd_start();
    do_read(e);
    check("R4 rd_start keeps ptr", rd_byte, 8'h06);

    // R9: request bit clear
    set_ptr(8'h1A);
    do_write(8'h13);
    check("R9 ddc off", {7'd0, ddc_mode}, 8'h00);
    set_ptr(8'h1A);
    do_rd_start();
    do_read(e);
    check("R9 req cleared", rd_byte, 8'h00);

    // R10: writes elsewhere change nothing, then grant again survives a neighbour write
    set_ptr(8'h1A);
    do_write(8'h06);
    do_write(8'hFB);
    check("R10 neighbour write", {7'd0, ddc_mode}, 8'h01);

    // R3: wrap from 0xFF to 0x00, visible by reaching the id register
    set_ptr(8'hFF);
    do_write(8'h00);
    do_rd_start();
    for (int i = 0; i < 27; i++) do_read(e);
    do_read(e);
    check("R3 wrap", rd_byte, 8'hB0);

    // random traffic against the model
    for (int n = 0; n < 600; n++) begin
      pick = $urandom_range(0, 9);
      case ($urandom_range(0, 4))
        0: a = 8'h1A;
        1: a = 8'h1B;
        2: a = 8'h3C;
        3: a = 8'h3D;
        default: a = 8'($urandom);
      endcase
      d = 8'($urandom);
      if (pick < 2) begin
        set_ptr(a);
      end else if (pick < 3) begin
        do_rd_start();
      end else if (pick < 5) begin
        do_wr_start();
      end else if (pick < 7) begin
        do_write(d);
        check("R7 R8 R9 random mode", {7'd0, ddc_mode}, {7'd0, m_ddc});
      end else begin
        a = m_ptr;
        do_read(e);
        check(tag_for(a), rd_byte, e);
      end
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule